// File: doc/BRIEF.md
# Double-Banked Hypothesis Hash Table

This block keeps the set of live search hypotheses for a frame-synchronous Viterbi search. Each hypothesis is a state identifier paired with an unsigned likelihood score, and a higher score is better. The storage is two hash-addressed banks. During a frame one bank is the source list: the search walks it entry by entry to learn which states are active. The other bank is the destination list, and the survivors for the next frame are inserted into it. A one-cycle frame-advance pulse exchanges the two roles. The bank that was filled becomes the one that is read, and the bank whose contents have now been consumed is emptied so that it can receive the next frame.

Insertion uses open addressing. The home slot comes from folding the identifier, and collisions move forward by linear probing up to a bounded number of probes. When a state is inserted a second time it is merged into the existing entry, which keeps the better of the two scores. An insert that exhausts its probes is dropped and raises a sticky overflow flag. A request/response readout port walks the valid entries of the read bank in slot order. A count output gives the occupancy of the read bank.

Top module: `hyp_pingpong_table`

## Requirements
- R1: After reset both banks are empty. Bank 0 is the write bank, `rd_count_o` is 0, `ovf_o` is 0 and `ins_ready_o` is 1.
- R2: The home slot of an identifier is the XOR of all its DEPTH_LOG2-bit chunks; with the defaults this is `id[7:0] ^ id[15:8]`. A probe that meets an occupied slot holding a different identifier moves on to the next slot, wrapping modulo the bank depth. At most MAX_PROBE slots are examined (default 16).
- R3: An insert is accepted on a clock edge where `ins_valid_i` and `ins_ready_o` are high and `frame_swap_i` is low. The engine examines one slot per cycle. `ins_done_o` pulses in the cycle after the decisive probe. An identifier not yet present is stored in the first free slot on its probe path and reports result code 0.
- R4: If the identifier is already present, no new entry is made. When the new score is strictly higher it replaces the stored score and the result code is 1. Otherwise the stored score stays and the result code is 2.
- R5: If MAX_PROBE slots are all held by other identifiers, nothing is written and the result code is 3. `ovf_o` rises with that result and stays high until the next frame advance.
- R6: A `frame_swap_i` pulse exchanges the banks at the next edge. The bank that was written becomes the read bank with its contents intact. The new write bank is emptied. `ovf_o` clears, the readout cursor returns to slot 0, and any insert or readout still in progress is dropped.
- R7: `rd_count_o` equals the number of valid entries in the read bank. Inserts never change it.
- R8: Each `rd_req_i` accepted while `rd_busy_o` is low returns the next valid read-bank entry in ascending slot order, as a one-cycle `rd_valid_o` with `rd_id_o`/`rd_score_o`. Once no entries remain, every request answers with a one-cycle `rd_end_o` instead.
- R9: Inserts during a frame never alter the entries returned by readout of the read bank.
- R10: `ins_ready_o` is low from the edge that accepts an insert until the edge that raises `ins_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_swap_i | input | 1 | Frame advance: exchange the read and write banks |
| ins_valid_i | input | 1 | Insert request |
| ins_id_i | input | ID_W | State identifier to insert |
| ins_score_i | input | SCORE_W | Likelihood score to insert |
| ins_ready_o | output | 1 | Insert engine idle, request can be taken |
| ins_done_o | output | 1 | One-cycle pulse: insert finished |
| ins_result_o | output | 2 | 0 stored, 1 merged and raised, 2 merged and kept, 3 overflow |
| ovf_o | output | 1 | Sticky overflow flag for the current write bank |
| rd_req_i | input | 1 | Request the next read-bank entry |
| rd_busy_o | output | 1 | Readout walk in progress |
| rd_valid_o | output | 1 | One-cycle pulse: entry presented |
| rd_id_o | output | ID_W | Identifier of the presented entry |
| rd_score_o | output | SCORE_W | Score of the presented entry |
| rd_end_o | output | 1 | One-cycle pulse: no entries remain |
| rd_count_o | output | DEPTH_LOG2+1 | Valid entries in the read bank |

## Verification
Several properties are checked on every cycle. The insert handshake must hold: ready drops after an accepted insert, and a done pulse only follows a busy period. The overflow flag must rise with an overflow result, stay set until the frame advance and clear on it. The read-bank count must stay frozen between frame advances, and the readout pulses must be mutually exclusive. Other behaviours need the bench scenarios, which track a model of both banks. These are the hash placement with wraparound, the max-merge outcome of duplicates, the exact slot order of the readout, the emptying of the recycled bank, and whether the read bank survives a full frame of random inserts.

// File: rtl/hypt_pkg.sv
// Package: shared types for the double-banked hypothesis table.
// Assumes nothing beyond IEEE 1800-2017 packages.
package hypt_pkg;

    // Outcome of one insert operation
    typedef enum logic [1:0] {
        RES_STORED = 2'd0,
        RES_RAISED = 2'd1,
        RES_KEPT   = 2'd2,
        RES_FULL   = 2'd3
    } ins_res_e;

    // State of the readout walker
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_SCAN = 1'b1
    } walk_state_e;

endpackage

// File: rtl/hypt_bank.sv
// Module: one hash bank of the hypothesis table.
// Holds 2**AW slots of {valid, id, score} plus an occupancy counter.
// Port A is the lookup port of the insert engine and port B the readout
// port; both are combinational reads. The valid bits and the counter
// clear in one cycle on clr_i. Id and score storage is not reset, because
// every read is qualified by the valid bit.
module hypt_bank #(
    parameter int ID_W = 16,
    parameter int SC_W = 16,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            we_i,
    input  logic            new_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [ID_W-1:0] wid_i,
    input  logic [SC_W-1:0] wsc_i,
    input  logic [AW-1:0]   pa_addr_i,
    output logic            pa_valid_o,
    output logic [ID_W-1:0] pa_id_o,
    output logic [SC_W-1:0] pa_sc_o,
    input  logic [AW-1:0]   pb_addr_i,
    output logic            pb_valid_o,
    output logic [ID_W-1:0] pb_id_o,
    output logic [SC_W-1:0] pb_sc_o,
    output logic [AW:0]     cnt_o
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0] vld_q;
    logic [ID_W-1:0]  id_mem [DEPTH];
    logic [SC_W-1:0]  sc_mem [DEPTH];
    logic [AW:0]      cnt_q;

    // Valid bits: cleared by reset or clear, set by a write
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            vld_q <= '0;
        end else if (we_i) begin
            vld_q[waddr_i] <= 1'b1;
        end
    end

    // Payload storage: written on insert or merge
    always_ff @(posedge clk) begin
        if (we_i && !clr_i) begin
            id_mem[waddr_i] <= wid_i;
            sc_mem[waddr_i] <= wsc_i;
        end
    end

    // Occupancy counter: counts only writes into empty slots
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (we_i && new_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pa_valid_o = vld_q[pa_addr_i];
    assign pa_id_o    = id_mem[pa_addr_i];
    assign pa_sc_o    = sc_mem[pa_addr_i];
    assign pb_valid_o = vld_q[pb_addr_i];
    assign pb_id_o    = id_mem[pb_addr_i];
    assign pb_sc_o    = sc_mem[pb_addr_i];
    assign cnt_o      = cnt_q;

endmodule

// File: rtl/hypt_probe.sv
// Module: insert engine with linear probing and max-merge.
// Takes one request at a time and examines one slot per cycle, starting
// at the folded-hash home slot. The engine stops at a free slot (store),
// at the same identifier (merge, keeping the higher score) or after
// MAX_PROBE slots (overflow). abort_i (frame advance) drops any in-flight
// insert and clears the sticky overflow flag. MAX_PROBE must be at least 2.
module hypt_probe
    import hypt_pkg::*;
#(
    parameter int ID_W      = 16,
    parameter int SC_W      = 16,
    parameter int AW        = 8,
    parameter int MAX_PROBE = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort_i,
    input  logic            req_valid_i,
    input  logic [ID_W-1:0] req_id_i,
    input  logic [SC_W-1:0] req_sc_i,
    output logic            ready_o,
    output logic [AW-1:0]   slot_o,
    input  logic            slot_valid_i,
    input  logic [ID_W-1:0] slot_id_i,
    input  logic [SC_W-1:0] slot_sc_i,
    output logic            we_o,
    output logic            wnew_o,
    output logic [ID_W-1:0] wid_o,
    output logic [SC_W-1:0] wsc_o,
    output logic            done_o,
    output ins_res_e        res_o,
    output logic            ovf_o
);
    localparam int PW     = $clog2(MAX_PROBE) + 1;
    localparam int CHUNKS = (ID_W + AW - 1) / AW;

    logic            busy_q;
    logic [ID_W-1:0] id_q;
    logic [SC_W-1:0] sc_q;
    logic [AW-1:0]   slot_q;
    logic [PW-1:0]   cnt_q;
    logic            done_q;
    ins_res_e        res_q;
    logic            ovf_q;

    logic            accept;
    logic            hit;
    logic            empty;
    logic            last;
    logic            better;
    logic [AW-1:0]   home;

    // Home slot: XOR fold of all AW-bit chunks of the identifier
    always_comb begin
        logic [CHUNKS*AW-1:0] padded;
        padded = '0;
        padded[ID_W-1:0] = req_id_i;
        home = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            home = home ^ padded[c*AW +: AW];
        end
    end

    assign accept = req_valid_i && !busy_q && !abort_i;
    assign empty  = !slot_valid_i;
    assign hit    = slot_valid_i && (slot_id_i == id_q);
    assign better = sc_q > slot_sc_i;
    assign last   = cnt_q == PW'(MAX_PROBE - 1);

    // Write strobes toward the selected write bank
    always_comb begin
        we_o   = busy_q && !abort_i && (empty || (hit && better));
        wnew_o = busy_q && !abort_i && empty;
    end

    // Probe sequencing: load, step, or finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            res_q  <= RES_STORED;
            slot_q <= '0;
            cnt_q  <= '0;
            id_q   <= '0;
            sc_q   <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (busy_q) begin
            if (empty) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= RES_STORED;
            end else if (hit) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= better ? RES_RAISED : RES_KEPT;
            end else if (last) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= RES_FULL;
            end else begin
                slot_q <= slot_q + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                id_q   <= req_id_i;
                sc_q   <= req_sc_i;
                slot_q <= home;
                cnt_q  <= '0;
            end
        end
    end

    // Sticky overflow flag for the current write bank
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            ovf_q <= 1'b0;
        end else if (busy_q && !empty && !hit && last) begin
            ovf_q <= 1'b1;
        end
    end

    assign ready_o = !busy_q;
    assign slot_o  = slot_q;
    assign wid_o   = id_q;
    assign wsc_o   = sc_q;
    assign done_o  = done_q;
    assign res_o   = res_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/hypt_scan.sv
// Module: readout walker over the read bank.
// Each accepted request scans forward from the cursor, one slot per cycle,
// and presents the first valid entry, leaving the cursor just past it.
// A cursor at the bank end answers every request with an end pulse.
// restart_i (frame advance) returns the cursor to slot 0 and drops a walk.
module hypt_scan
    import hypt_pkg::*;
#(
    parameter int ID_W = 16,
    parameter int SC_W = 16,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            req_i,
    output logic            busy_o,
    output logic [AW-1:0]   addr_o,
    input  logic            slot_valid_i,
    input  logic [ID_W-1:0] slot_id_i,
    input  logic [SC_W-1:0] slot_sc_i,
    output logic            out_valid_o,
    output logic [ID_W-1:0] out_id_o,
    output logic [SC_W-1:0] out_sc_o,
    output logic            out_end_o
);
    walk_state_e     st_q;
    logic [AW:0]     cur_q;
    logic            vld_q;
    logic            end_q;
    logic [ID_W-1:0] id_q;
    logic [SC_W-1:0] sc_q;

    // Walk sequencing and output capture
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            st_q  <= WALK_IDLE;
            cur_q <= '0;
            vld_q <= 1'b0;
            end_q <= 1'b0;
            id_q  <= '0;
            sc_q  <= '0;
        end else begin
            vld_q <= 1'b0;
            end_q <= 1'b0;
            if (st_q == WALK_IDLE) begin
                if (req_i) begin
                    st_q <= WALK_SCAN;
                end
            end else if (cur_q[AW]) begin
                st_q  <= WALK_IDLE;
                end_q <= 1'b1;
            end else if (slot_valid_i) begin
                st_q  <= WALK_IDLE;
                vld_q <= 1'b1;
                id_q  <= slot_id_i;
                sc_q  <= slot_sc_i;
                cur_q <= cur_q + 1'b1;
            end else begin
                cur_q <= cur_q + 1'b1;
            end
        end
    end

    assign busy_o      = st_q == WALK_SCAN;
    assign addr_o      = cur_q[AW-1:0];
    assign out_valid_o = vld_q;
    assign out_end_o   = end_q;
    assign out_id_o    = id_q;
    assign out_sc_o    = sc_q;

endmodule

// File: rtl/hyp_pingpong_table.sv
// Module: double-banked hypothesis hash table (top).
// Two hypt_bank instances; wsel_q names the write bank and the other bank
// is read. frame_swap_i toggles wsel_q, empties the bank about to be
// written, and restarts the insert engine and the readout walker. Assumes
// the frame advance is issued when both engines are idle; otherwise their
// work in progress is dropped.
module hyp_pingpong_table
    import hypt_pkg::*;
#(
    parameter int ID_W       = 16,
    parameter int SCORE_W    = 16,
    parameter int DEPTH_LOG2 = 8,
    parameter int MAX_PROBE  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_swap_i,
    input  logic                  ins_valid_i,
    input  logic [ID_W-1:0]       ins_id_i,
    input  logic [SCORE_W-1:0]    ins_score_i,
    output logic                  ins_ready_o,
    output logic                  ins_done_o,
    output logic [1:0]            ins_result_o,
    output logic                  ovf_o,
    input  logic                  rd_req_i,
    output logic                  rd_busy_o,
    output logic                  rd_valid_o,
    output logic [ID_W-1:0]       rd_id_o,
    output logic [SCORE_W-1:0]    rd_score_o,
    output logic                  rd_end_o,
    output logic [DEPTH_LOG2:0]   rd_count_o
);
    localparam int AW     = DEPTH_LOG2;
    localparam int NBANKS = 2;

    logic                wsel_q;
    logic                rsel;

    logic [AW-1:0]       eng_slot;
    logic                eng_we;
    logic                eng_new;
    logic [ID_W-1:0]     eng_wid;
    logic [SCORE_W-1:0]  eng_wsc;
    ins_res_e            eng_res;
    logic [AW-1:0]       scan_addr;

    logic                pa_v  [NBANKS];
    logic [ID_W-1:0]     pa_id [NBANKS];
    logic [SCORE_W-1:0]  pa_sc [NBANKS];
    logic                pb_v  [NBANKS];
    logic [ID_W-1:0]     pb_id [NBANKS];
    logic [SCORE_W-1:0]  pb_sc [NBANKS];
    logic [AW:0]         cnt   [NBANKS];

    // Bank role select: toggles on every frame advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel_q <= 1'b0;
        end else if (frame_swap_i) begin
            wsel_q <= ~wsel_q;
        end
    end

    assign rsel = ~wsel_q;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic is_wr;
        assign is_wr = (wsel_q == 1'(b));

        hypt_bank #(
            .ID_W (ID_W),
            .SC_W (SCORE_W),
            .AW   (AW)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (frame_swap_i && !is_wr),
            .we_i       (eng_we && is_wr),
            .new_i      (eng_new),
            .waddr_i    (eng_slot),
            .wid_i      (eng_wid),
            .wsc_i      (eng_wsc),
            .pa_addr_i  (eng_slot),
            .pa_valid_o (pa_v[b]),
            .pa_id_o    (pa_id[b]),
            .pa_sc_o    (pa_sc[b]),
            .pb_addr_i  (scan_addr),
            .pb_valid_o (pb_v[b]),
            .pb_id_o    (pb_id[b]),
            .pb_sc_o    (pb_sc[b]),
            .cnt_o      (cnt[b])
        );
    end

    hypt_probe #(
        .ID_W      (ID_W),
        .SC_W      (SCORE_W),
        .AW        (AW),
        .MAX_PROBE (MAX_PROBE)
    ) u_probe (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort_i      (frame_swap_i),
        .req_valid_i  (ins_valid_i),
        .req_id_i     (ins_id_i),
        .req_sc_i     (ins_score_i),
        .ready_o      (ins_ready_o),
        .slot_o       (eng_slot),
        .slot_valid_i (pa_v[wsel_q]),
        .slot_id_i    (pa_id[wsel_q]),
        .slot_sc_i    (pa_sc[wsel_q]),
        .we_o         (eng_we),
        .wnew_o       (eng_new),
        .wid_o        (eng_wid),
        .wsc_o        (eng_wsc),
        .done_o       (ins_done_o),
        .res_o        (eng_res),
        .ovf_o        (ovf_o)
    );

    hypt_scan #(
        .ID_W (ID_W),
        .SC_W (SCORE_W),
        .AW   (AW)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (frame_swap_i),
        .req_i        (rd_req_i),
        .busy_o       (rd_busy_o),
        .addr_o       (scan_addr),
        .slot_valid_i (pb_v[rsel]),
        .slot_id_i    (pb_id[rsel]),
        .slot_sc_i    (pb_sc[rsel]),
        .out_valid_o  (rd_valid_o),
        .out_id_o     (rd_id_o),
        .out_sc_o     (rd_score_o),
        .out_end_o    (rd_end_o)
    );

    assign ins_result_o = eng_res;
    assign rd_count_o   = cnt[rsel];

endmodule

// File: rtl/hyp_pingpong_table_chk.sv
// Module: protocol checker for hyp_pingpong_table, attached by bind.
// Observes ports only; all properties are disabled during reset.
module hyp_pingpong_table_chk #(
    parameter int DEPTH_LOG2 = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_swap_i,
    input logic                ins_valid_i,
    input logic                ins_ready_o,
    input logic                ins_done_o,
    input logic [1:0]          ins_result_o,
    input logic                ovf_o,
    input logic                rd_busy_o,
    input logic                rd_valid_o,
    input logic                rd_end_o,
    input logic [DEPTH_LOG2:0] rd_count_o
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid_i && ins_ready_o && !frame_swap_i) |=> !ins_ready_o);

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_done_o |-> $past(!ins_ready_o));

    // R5
    full_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done_o && ins_result_o == 2'd3) |-> ovf_o);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !frame_swap_i) |=> ovf_o);

    // R6
    swap_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_swap_i |=> !ovf_o);

    // R7
    count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_swap_i |=> $stable(rd_count_o));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count_o <= (DEPTH_LOG2+1)'(DEPTH));

    // R8
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && rd_end_o));

    // R8
    rd_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o || rd_end_o) |-> $past(rd_busy_o));

endmodule

bind hyp_pingpong_table hyp_pingpong_table_chk #(
    .DEPTH_LOG2 (DEPTH_LOG2)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_swap_i (frame_swap_i),
    .ins_valid_i  (ins_valid_i),
    .ins_ready_o  (ins_ready_o),
    .ins_done_o   (ins_done_o),
    .ins_result_o (ins_result_o),
    .ovf_o        (ovf_o),
    .rd_busy_o    (rd_busy_o),
    .rd_valid_o   (rd_valid_o),
    .rd_end_o     (rd_end_o),
    .rd_count_o   (rd_count_o)
);

// File: tb/test_hyp_pingpong_table.sv
// Bench: directed corner cases plus seeded random inserts, checked against
// a bench model of both banks built from the requirements.
module test_hyp_pingpong_table;
    localparam int IDW   = 16;
    localparam int SCW   = 16;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int MP    = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_swap = 1'b0;
    logic           ins_valid = 1'b0;
    logic [IDW-1:0] ins_id = '0;
    logic [SCW-1:0] ins_score = '0;
    logic           ins_ready_o, ins_done_o, ovf_o;
    logic [1:0]     ins_result_o;
    logic           rd_req = 1'b0;
    logic           rd_busy_o, rd_valid_o, rd_end_o;
    logic [IDW-1:0] rd_id_o;
    logic [SCW-1:0] rd_score_o;
    logic [AW:0]    rd_count_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench model of the two banks
    bit             mv  [2][DEPTH];
    logic [IDW-1:0] mid [2][DEPTH];
    logic [SCW-1:0] msc [2][DEPTH];
    int             mcnt[2];
    int             wb = 0;
    bit             movf = 0;

    hyp_pingpong_table #(
        .ID_W(IDW), .SCORE_W(SCW), .DEPTH_LOG2(AW), .MAX_PROBE(MP)
    ) i_hyp_pingpong_table (
        .clk(clk), .rst_n(rst_n), .frame_swap_i(frame_swap),
        .ins_valid_i(ins_valid), .ins_id_i(ins_id), .ins_score_i(ins_score),
        .ins_ready_o(ins_ready_o), .ins_done_o(ins_done_o),
        .ins_result_o(ins_result_o), .ovf_o(ovf_o),
        .rd_req_i(rd_req), .rd_busy_o(rd_busy_o), .rd_valid_o(rd_valid_o),
        .rd_id_o(rd_id_o), .rd_score_o(rd_score_o), .rd_end_o(rd_end_o),
        .rd_count_o(rd_count_o)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int home_of(logic [IDW-1:0] id);
        return int'(id[7:0] ^ id[15:8]);
    endfunction

    // model of one insert into the write bank (R2..R5)
    function automatic int model_ins(logic [IDW-1:0] id, logic [SCW-1:0] sc);
        int s = home_of(id);
        for (int k = 0; k < MP; k++) begin
            if (!mv[wb][s]) begin
                mv[wb][s] = 1'b1; mid[wb][s] = id; msc[wb][s] = sc;
                mcnt[wb]++;
                return 0;
            end
            if (mid[wb][s] == id) begin
                if (sc > msc[wb][s]) begin
                    msc[wb][s] = sc;
                    return 1;
                end
                return 2;
            end
            s = (s + 1) % DEPTH;
        end
        movf = 1'b1;
        return 3;
    endfunction

    function automatic void model_swap();
        wb = wb ^ 1;
        for (int s = 0; s < DEPTH; s++) mv[wb][s] = 1'b0;
        mcnt[wb] = 0;
        movf = 1'b0;
    endfunction

    task automatic do_ins(logic [IDW-1:0] id, logic [SCW-1:0] sc, string req);
        int t = 0;
        int exp;
        @(negedge clk);
        while (!ins_ready_o) @(negedge clk);
        ins_valid = 1'b1; ins_id = id; ins_score = sc;
        @(negedge clk);
        ins_valid = 1'b0;
        if (!ins_done_o) chk(!ins_ready_o, "R10", "ready while probing", int'(ins_ready_o), 0);
        while (!ins_done_o && t < 100) begin
            @(negedge clk);
            t++;
        end
        exp = model_ins(id, sc);
        chk(ins_done_o && int'(ins_result_o) == exp, req, "insert result",
            ins_done_o ? int'(ins_result_o) : -1, exp);
        chk(ovf_o == movf, "R5", "overflow flag", int'(ovf_o), int'(movf));
    endtask

    task automatic do_swap();
        @(negedge clk);
        frame_swap = 1'b1;
        @(negedge clk);
        frame_swap = 1'b0;
        model_swap();
        chk(ovf_o == 1'b0, "R6", "flag after swap", int'(ovf_o), 0);
        chk(int'(rd_count_o) == mcnt[wb ^ 1], "R7", "read count after swap",
            int'(rd_count_o), mcnt[wb ^ 1]);
    endtask

    task automatic do_read(output bit v, output bit e, output logic [IDW-1:0] id,
                           output logic [SCW-1:0] sc);
        int t = 0;
        @(negedge clk);
        while (rd_busy_o) @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        while (!rd_valid_o && !rd_end_o && t < 2 * DEPTH + 10) begin
            @(negedge clk);
            t++;
        end
        v = rd_valid_o; e = rd_end_o; id = rd_id_o; sc = rd_score_o;
    endtask

    // full walk of the read bank compared with the model, slot order
    task automatic check_readout(string req);
        bit v, e;
        logic [IDW-1:0] id;
        logic [SCW-1:0] sc;
        int rb = wb ^ 1;
        for (int s = 0; s < DEPTH; s++) begin
            if (mv[rb][s]) begin
                do_read(v, e, id, sc);
                chk(v && !e && id == mid[rb][s], req, "readout id", int'(id), int'(mid[rb][s]));
                chk(sc == msc[rb][s], req, "readout score", int'(sc), int'(msc[rb][s]));
            end
        end
        do_read(v, e, id, sc);
        chk(e && !v, "R8", "end after last entry", int'(e), 1);
        do_read(v, e, id, sc);
        chk(e && !v, "R8", "end repeats", int'(e), 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0a17);
        for (int b = 0; b < 2; b++) begin
            mcnt[b] = 0;
            for (int s = 0; s < DEPTH; s++) mv[b][s] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ins_ready_o == 1'b1, "R1", "ready after reset", int'(ins_ready_o), 1);
        chk(ovf_o == 1'b0, "R1", "flag after reset", int'(ovf_o), 0);
        chk(rd_count_o == '0, "R1", "count after reset", int'(rd_count_o), 0);
        check_readout("R1");

        // R3 / R4: store, raise, keep
        do_ins(16'h0050, 16'd100, "R3");
        do_ins(16'h0050, 16'd200, "R4");
        do_ins(16'h0050, 16'd150, "R4");
        do_ins(16'h0050, 16'd200, "R4");

        // R2: same home 0xFE, run wraps past the bank end
        for (int k = 0; k < MP; k++) begin
            do_ins(IDW'((k << 8) | (k ^ 8'hFE)), SCW'(k + 1), "R2");
        end
        do_ins(IDW'((15 << 8) | (15 ^ 8'hFE)), 16'd900, "R2");
        // R5: the seventeenth identifier of the same home overflows
        do_ins(IDW'((16 << 8) | (16 ^ 8'hFE)), 16'd5, "R5");
        do_ins(16'h0051, 16'd7, "R3");
        chk(ovf_o == 1'b1, "R5", "flag held", int'(ovf_o), 1);

        do_swap();
        check_readout("R6");
        // R6: swapping twice with no inserts leaves an empty read bank
        do_swap();
        chk(rd_count_o == '0, "R6", "recycled bank emptied", int'(rd_count_o), 0);
        check_readout("R6");

        // random frames with R9 check of the read bank after inserts
        for (int f = 0; f < 6; f++) begin
            int n = $urandom_range(60, 320);
            for (int i = 0; i < n; i++) begin
                logic [IDW-1:0] id = IDW'($urandom_range(0, 1023));
                logic [SCW-1:0] sc = SCW'($urandom);
                do_ins(id, sc, "R4");
            end
            chk(int'(rd_count_o) == mcnt[wb ^ 1], "R7", "count unchanged by inserts",
                int'(rd_count_o), mcnt[wb ^ 1]);
            check_readout("R9");
            do_swap();
        end
        check_readout("R8");

        summary();
        $finish;
    end

endmodule